// File: doc/BRIEF.md
# Packed Two-Lane Shifter with Rounding and Saturation

This block shifts a 32-bit operand as two independent 16-bit lanes in a single registered stage. Each request picks one of three shift kinds (arithmetic right, logical right, left) and takes the per-lane shift count from one of two sources. The count comes either from the low four bits of the matching lane of a second operand, or from a shared immediate. A two-bit mode field switches right shifts to round-to-nearest and left shifts to clamp on overflow.

The issuing pipeline also presents the destination and source register numbers. Only a window of sixteen to twenty-nine is legal. Within that window, the first source register number sets the signedness of a saturating left shift: the lower bank (16..23) is signed and the upper bank (24..29) is unsigned. A request that names a register outside the window produces zero and raises a flag. The result, its strobe and the flag appear one clock after the request.

Top module: `lane_shift_unit`

## Requirements
- R1: The output strobe `res_valid` equals the value `in_valid` had one clock earlier. `res` updates only in the cycle after an accepted request and otherwise keeps its value.
- R2: With `shift_kind` = 2'b00, each lane is shifted right arithmetically, filling with copies of the lane's top bit.
- R3: With `shift_kind` = 2'b01, each lane is shifted right logically, filling with zeros.
- R4: With `shift_kind` = 2'b10 and plain mode, each lane is shifted left. Bits that leave the 16-bit lane are lost.
- R5: When `use_imm` is 1, both lanes shift by `imm_amt`. When `use_imm` is 0, lane k (bits 16k+15..16k) shifts by bits 16k+3..16k of `opb`.
- R6: With `mode` = 2'b01, a right shift by n>0 adds bit n-1 of the original lane to the shifted lane.
- R7: With `mode` = 2'b01, a left shift whose result does not represent the exact product clamps the lane. When `ra_idx` is in 16..23 the lane is signed and clamps to 0x7FFF or 0x8000. When `ra_idx` is in 24..29 the lane is unsigned and clamps to 0xFFFF.
- R8: If `rd_idx` or `ra_idx` lies outside 16..29, the result is zero and `bad_reg` is 1 for one cycle. The same holds if `rb_idx` lies outside 16..29 while `use_imm` = 0. `rb_idx` is ignored when `use_imm` = 1.
- R9: A lane with a shift count of zero is passed through unchanged, in every kind and mode.
- R10: `shift_kind` = 2'b11 gives a zero result with no flag. Mode values 2'b10 and 2'b11 act as plain mode 2'b00.
- R11: A synchronous reset clears `res`, `res_valid` and `bad_reg`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| shift_kind | input | 2 | 00 arithmetic right, 01 logical right, 10 left, 11 none |
| use_imm | input | 1 | Take the count from `imm_amt` instead of `opb` |
| imm_amt | input | 4 | Immediate shift count |
| mode | input | 2 | 01 rounding/saturating, otherwise plain |
| opa | input | 32 | Packed lanes to shift |
| opb | input | 32 | Packed per-lane counts (low 4 bits of each lane) |
| rd_idx | input | 5 | Destination register number |
| ra_idx | input | 5 | First source register number, selects signed bank |
| rb_idx | input | 5 | Second source register number |
| res | output | 32 | Registered packed result |
| res_valid | output | 1 | Result strobe |
| bad_reg | output | 1 | Register number out of the legal window |

## Verification
A saturating left shift and a register-window violation can hit the same request. In that case the flag must win and the clamp value must not leak into the result. The bench provokes this with a signed-bank overflowing left shift whose `rb_idx` is 30 while `use_imm` is 0. It then reissues the same operands with `use_imm` set, which must yield the clamped lanes with no flag. A separate overlap occurs when one lane saturates and the other does not in the same cycle. The bench's behavioural model computes both lanes independently, so such a pair is judged lane by lane.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;
   typedef enum logic [1:0] {
      SK_ASR  = 2'b00,
      SK_LSR  = 2'b01,
      SK_LSL  = 2'b10,
      SK_NONE = 2'b11
   } shift_kind_e;

   localparam logic [1:0] MODE_ALT = 2'b01;
endpackage

// File: rtl/lane_shift_slice.sv
module lane_shift_slice
   import lane_shift_pkg::*;
#(
   parameter int LANE_W = 16,
   parameter int AMT_W  = 4
) (
   input  logic [LANE_W-1:0] x,
   input  logic [AMT_W-1:0]  amt,
   input  shift_kind_e       kind,
   input  logic              alt,
   input  logic              sgn,
   output logic [LANE_W-1:0] y
);
   localparam logic [LANE_W-1:0] S_MAX = {1'b0, {(LANE_W-1){1'b1}}};
   localparam logic [LANE_W-1:0] S_MIN = {1'b1, {(LANE_W-1){1'b0}}};
   localparam logic [LANE_W-1:0] U_MAX = {LANE_W{1'b1}};

   logic [LANE_W-1:0] asr, lsr, lsl, below, back_s, back_u, sat_val, rnd_add;
   logic              rbit, ovf;

   assign asr    = $signed(x) >>> amt;
   assign lsr    = x >> amt;
   assign lsl    = x << amt;
   assign below  = x >> (amt - AMT_W'(1));
   assign rbit   = (amt != '0) & below[0];
   assign rnd_add = {{(LANE_W-1){1'b0}}, rbit & alt};

   assign back_s = $signed(lsl) >>> amt;
   assign back_u = lsl >> amt;
   assign ovf    = sgn ? (back_s != x) : (back_u != x);
   assign sat_val = sgn ? (x[LANE_W-1] ? S_MIN : S_MAX) : U_MAX;

   always_comb begin
      unique case (kind)
         SK_ASR:  y = asr + rnd_add;
         SK_LSR:  y = lsr + rnd_add;
         SK_LSL:  y = (alt && ovf) ? sat_val : lsl;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/shift_reg_gate.sv
module shift_reg_gate #(
   parameter int IDX_W   = 5,
   parameter int BANK_LO = 16,
   parameter int BANK_HI = 29,
   parameter int SGN_HI  = 23
) (
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [IDX_W-1:0] ra_idx,
   input  logic [IDX_W-1:0] rb_idx,
   input  logic             use_imm,
   output logic             legal,
   output logic             signed_bank
);
   localparam int NSRC = 3;
   localparam logic [IDX_W-1:0] LO_V  = IDX_W'(BANK_LO);
   localparam logic [IDX_W-1:0] HI_V  = IDX_W'(BANK_HI);
   localparam logic [IDX_W-1:0] SHI_V = IDX_W'(SGN_HI);

   logic [IDX_W-1:0] idx [NSRC];
   logic [NSRC-1:0]  in_rng, needed;

   assign idx[0] = rd_idx;
   assign idx[1] = ra_idx;
   assign idx[2] = rb_idx;
   assign needed = {~use_imm, 1'b1, 1'b1};

   for (genvar i = 0; i < NSRC; i++) begin : g_rng
      assign in_rng[i] = (idx[i] >= LO_V) && (idx[i] <= HI_V);
   end

   assign legal       = &(in_rng | ~needed);
   assign signed_bank = (ra_idx <= SHI_V);
endmodule

// File: rtl/lane_shift_unit.sv
module lane_shift_unit
   import lane_shift_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int LANE_W  = 16,
   parameter int IDX_W   = 5,
   parameter int BANK_LO = 16,
   parameter int BANK_HI = 29,
   parameter int SGN_HI  = 23,
   localparam int AMT_W  = $clog2(LANE_W)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              in_valid,
   input  logic [1:0]        shift_kind,
   input  logic              use_imm,
   input  logic [AMT_W-1:0]  imm_amt,
   input  logic [1:0]        mode,
   input  logic [DATA_W-1:0] opa,
   input  logic [DATA_W-1:0] opb,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [IDX_W-1:0]  ra_idx,
   input  logic [IDX_W-1:0]  rb_idx,
   output logic [DATA_W-1:0] res,
   output logic              res_valid,
   output logic              bad_reg
);
   localparam int NUM_LANES = DATA_W / LANE_W;

   if (NUM_LANES * LANE_W != DATA_W) begin : g_bad_split
      $error("DATA_W must be a whole number of lanes");
   end
   if ((1 << AMT_W) != LANE_W) begin : g_bad_lane
      $error("LANE_W must be a power of two");
   end
   if (BANK_LO > SGN_HI || SGN_HI > BANK_HI) begin : g_bad_bank
      $error("bank limits out of order");
   end

   shift_kind_e       kind;
   logic              alt, legal, signed_bank;
   logic [DATA_W-1:0] lanes_out;

   assign kind = shift_kind_e'(shift_kind);
   assign alt  = (mode == MODE_ALT);

   shift_reg_gate #(
      .IDX_W(IDX_W), .BANK_LO(BANK_LO), .BANK_HI(BANK_HI), .SGN_HI(SGN_HI)
   ) u_gate (
      .rd_idx(rd_idx), .ra_idx(ra_idx), .rb_idx(rb_idx), .use_imm(use_imm),
      .legal(legal), .signed_bank(signed_bank)
   );

   for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
      logic [AMT_W-1:0] amt;
      assign amt = use_imm ? imm_amt : opb[l*LANE_W +: AMT_W];
      lane_shift_slice #(.LANE_W(LANE_W), .AMT_W(AMT_W)) u_slice (
         .x(opa[l*LANE_W +: LANE_W]), .amt(amt), .kind(kind),
         .alt(alt), .sgn(signed_bank), .y(lanes_out[l*LANE_W +: LANE_W])
      );
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         res       <= '0;
         res_valid <= 1'b0;
         bad_reg   <= 1'b0;
      end else begin
         res_valid <= in_valid;
         bad_reg   <= in_valid & ~legal;
         if (in_valid) res <= legal ? lanes_out : '0;
      end
   end
endmodule

// File: rtl/lane_shift_checker.sv
module lane_shift_checker #(
   parameter int DATA_W  = 32,
   parameter int IDX_W   = 5,
   parameter int AMT_W   = 4,
   parameter int BANK_LO = 16,
   parameter int BANK_HI = 29
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [1:0]        shift_kind,
   input logic              use_imm,
   input logic [AMT_W-1:0]  imm_amt,
   input logic [DATA_W-1:0] opa,
   input logic [IDX_W-1:0]  rd_idx,
   input logic [IDX_W-1:0]  ra_idx,
   input logic [IDX_W-1:0]  rb_idx,
   input logic [DATA_W-1:0] res,
   input logic              res_valid,
   input logic              bad_reg
);
   localparam logic [IDX_W-1:0] LO_V = IDX_W'(BANK_LO);
   localparam logic [IDX_W-1:0] HI_V = IDX_W'(BANK_HI);

   logic ok_idx;
   assign ok_idx = (rd_idx >= LO_V) && (rd_idx <= HI_V) &&
                   (ra_idx >= LO_V) && (ra_idx <= HI_V) &&
                   (use_imm || ((rb_idx >= LO_V) && (rb_idx <= HI_V)));

   p_valid_follows_r1: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> res_valid);
   p_valid_drops_r1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !res_valid);
   p_hold_idle_r1: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(res));
   p_bad_zero_r8: assert property (@(posedge clk) disable iff (rst)
      bad_reg |-> (res == '0));
   p_bad_ra_r8: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (ra_idx < LO_V || ra_idx > HI_V)) |=> bad_reg);
   p_zero_amt_r9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && use_imm && imm_amt == '0 && ok_idx && shift_kind != 2'b11)
      |=> (res == $past(opa)));
   p_reset_clear_r11: assert property (@(posedge clk)
      rst |=> (!res_valid && !bad_reg && res == '0));
endmodule

bind lane_shift_unit lane_shift_checker #(
   .DATA_W(DATA_W), .IDX_W(IDX_W), .AMT_W(AMT_W),
   .BANK_LO(BANK_LO), .BANK_HI(BANK_HI)
) u_chk (
   .clk(clk), .rst(rst), .in_valid(in_valid), .shift_kind(shift_kind),
   .use_imm(use_imm), .imm_amt(imm_amt), .opa(opa), .rd_idx(rd_idx),
   .ra_idx(ra_idx), .rb_idx(rb_idx), .res(res), .res_valid(res_valid),
   .bad_reg(bad_reg)
);

// File: tb/tb_lane_shift_unit.sv
`timescale 1ns/1ps
module tb_lane_shift_unit;
   logic        clk = 1'b0;
   logic        rst;
   logic        in_valid;
   logic [1:0]  shift_kind;
   logic        use_imm;
   logic [3:0]  imm_amt;
   logic [1:0]  mode;
   logic [31:0] opa, opb;
   logic [4:0]  rd_idx, ra_idx, rb_idx;
   logic [31:0] res;
   logic        res_valid, bad_reg;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic [31:0] exp_res = '0;
   logic        exp_valid = 1'b0, exp_bad = 1'b0;
   string       exp_tag = "R11";

   always #2.5 clk = ~clk;

   lane_shift_unit dut (
      .clk(clk), .rst(rst), .in_valid(in_valid), .shift_kind(shift_kind),
      .use_imm(use_imm), .imm_amt(imm_amt), .mode(mode), .opa(opa), .opb(opb),
      .rd_idx(rd_idx), .ra_idx(ra_idx), .rb_idx(rb_idx),
      .res(res), .res_valid(res_valid), .bad_reg(bad_reg)
   );

   // Behavioural reference: returns {bad, result}
   function automatic logic [32:0] model(input int kind, input int md, input bit ui,
                                         input int imm, input logic [31:0] a,
                                         input logic [31:0] b, input int rd,
                                         input int ra, input int rb);
      logic [31:0] r = '0;
      bit legal = (rd >= 16 && rd <= 29) && (ra >= 16 && ra <= 29) &&
                  (ui || (rb >= 16 && rb <= 29));
      bit alt = (md == 1);
      if (!legal) return {1'b1, 32'h0};
      for (int l = 0; l < 2; l++) begin
         int x = int'(a[16*l +: 16]);
         int s = ui ? imm : int'(b[16*l +: 4]);
         int xs = (x >= 32768) ? x - 65536 : x;
         longint p;
         int y = 0;
         int rb_bit = (s > 0) ? ((x >> (s - 1)) & 1) : 0;
         case (kind)
            0: y = (xs >>> s) + (alt ? rb_bit : 0);
            1: y = (x >> s) + (alt ? rb_bit : 0);
            2: begin
               if (!alt) y = (x << s);
               else if (ra <= 23) begin
                  p = longint'(xs) * (longint'(1) << s);
                  if (p > 32767) y = 32767;
                  else if (p < -32768) y = -32768;
                  else y = int'(p);
               end else begin
                  p = longint'(x) * (longint'(1) << s);
                  y = (p > 65535) ? 65535 : int'(p);
               end
            end
            default: y = 0;
         endcase
         r[16*l +: 16] = 16'(y);
      end
      return {1'b0, r};
   endfunction

   task automatic check_now();
      checks++;
      if (res_valid !== exp_valid || bad_reg !== exp_bad || res !== exp_res) begin
         errors++;
         $display("FAIL %s: got res=%h valid=%b bad=%b expected res=%h valid=%b bad=%b",
                  exp_tag, res, res_valid, bad_reg, exp_res, exp_valid, exp_bad);
      end
   endtask

   task automatic step(input string tag, input bit v, input int kind, input int md,
                       input bit ui, input int imm, input logic [31:0] a,
                       input logic [31:0] b, input int rd, input int ra, input int rb);
      logic [32:0] m;
      @(negedge clk);
      check_now();
      in_valid = v; shift_kind = 2'(kind); mode = 2'(md); use_imm = ui;
      imm_amt = 4'(imm); opa = a; opb = b;
      rd_idx = 5'(rd); ra_idx = 5'(ra); rb_idx = 5'(rb);
      m = model(kind, md, ui, imm, a, b, rd, ra, rb);
      exp_valid = v;
      exp_bad = v & m[32];
      if (v) exp_res = m[31:0];
      exp_tag = tag;
   endtask

   initial begin
      rst = 1'b1; in_valid = 0; shift_kind = 0; use_imm = 0; imm_amt = 0;
      mode = 0; opa = 0; opb = 0; rd_idx = 16; ra_idx = 16; rb_idx = 16;
      repeat (3) @(negedge clk);
      check_now();                       // R11 reset state
      rst = 1'b0;
      step("R2",  1, 0, 0, 1, 4, 32'h8000_7FF0, 0, 16, 17, 18);
      step("R3",  1, 1, 0, 1, 4, 32'h8000_7FF0, 0, 16, 17, 18);
      step("R4",  1, 2, 0, 0, 0, 32'h1234_0003, 32'h0003_000F, 16, 17, 18);
      step("R5",  1, 1, 0, 0, 9, 32'hF0F0_F0F0, 32'hFFF1_0008, 20, 21, 22);
      step("R6",  1, 0, 1, 1, 1, 32'hFFFB_0006, 0, 16, 17, 18);
      step("R6",  1, 1, 1, 1, 2, 32'h000B_8001, 0, 16, 17, 18);
      step("R7",  1, 2, 1, 1, 1, 32'h4000_C000, 0, 16, 16, 18);
      step("R7",  1, 2, 1, 1, 2, 32'h4000_C000, 0, 16, 23, 18);
      step("R7",  1, 2, 1, 1, 1, 32'h8000_0001, 0, 16, 24, 18);
      step("R7",  1, 2, 1, 0, 0, 32'h0001_7FFF, 32'h000F_0000, 29, 29, 29);
      step("R1",  0, 0, 0, 1, 3, 32'hFFFF_FFFF, 0, 16, 17, 18);
      step("R1",  0, 2, 0, 1, 3, 32'h1111_1111, 0, 16, 17, 18);
      step("R8",  1, 0, 0, 1, 1, 32'h1234_5678, 0, 16, 15, 18);
      step("R8",  1, 0, 0, 1, 1, 32'h1234_5678, 0, 30, 17, 18);
      step("R8",  1, 0, 0, 1, 1, 32'h1234_5678, 0, 16, 17, 30);
      step("R8",  1, 2, 1, 0, 0, 32'h4000_4000, 32'h0001_0001, 16, 16, 30);
      step("R7",  1, 2, 1, 1, 1, 32'h4000_4000, 0, 16, 16, 30);
      step("R9",  1, 0, 1, 1, 0, 32'h8001_7FFF, 0, 16, 17, 18);
      step("R9",  1, 1, 1, 1, 0, 32'h8001_7FFF, 0, 16, 17, 18);
      step("R9",  1, 2, 1, 0, 0, 32'hFFFF_8000, 32'h0010_0020, 16, 24, 18);
      step("R10", 1, 3, 0, 1, 2, 32'hABCD_1234, 0, 16, 17, 18);
      step("R10", 1, 0, 2, 1, 1, 32'hFFFB_0007, 0, 16, 17, 18);
      step("R10", 1, 2, 3, 1, 3, 32'h4000_0FFF, 0, 16, 17, 18);
      for (int i = 0; i < 400; i++) begin
         step("R5", ($urandom % 5) != 0, $urandom % 4, $urandom % 4, $urandom % 2,
              $urandom % 16, $urandom, $urandom, 14 + ($urandom % 18),
              14 + ($urandom % 18), 14 + ($urandom % 18));
      end
      step("R1", 0, 0, 0, 0, 0, 0, 0, 16, 16, 16);
      @(negedge clk);
      check_now();
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: got hang expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule